// File: doc/BRIEF.md
# Burst Conversion Sequencer

This block controls a successive-approximation converter so that a single convert-start pulse produces a whole burst of conversions. On an accepted start it records the burst settings. If the converter is kept biased, it begins with a tracking slot. If not, it first powers the analog core up while it tracks. It then alternates tracking and converting until the programmed number of conversions is complete. At that point it drops busy, raises a one-cycle done pulse and, if the converter is not kept biased, returns the analog core to the unpowered state.

All phase lengths are counted in SAR clock ticks, which arrive as a one-cycle enable `sar_tick` on the system clock. The bit-cycling of a conversion is modelled as a fixed run of RES_W+1 ticks. A mode input can replace every tracking slot with a fixed four-tick slot, including one extra slot placed before the first conversion.

The controller has four states. ST_IDLE waits for a start. ST_PWRUP is power-up with tracking. ST_TRACK is a tracking slot. ST_CONV is a conversion. The transitions are:
- start: ST_IDLE→ST_PWRUP when the keep-on bit is 0, or ST_IDLE→ST_TRACK when it is 1.
- warm: ST_PWRUP→ST_TRACK in fixed-slot mode, otherwise ST_PWRUP→ST_CONV.
- sample: ST_TRACK→ST_CONV.
- next: ST_CONV→ST_TRACK while conversions remain.
- finish: ST_CONV→ST_IDLE after the last conversion.

Top module: `bseq_burst_ctrl`

## Requirements
- R1: After reset, `pwrup_ph`, `track`, `convert`, `busy` and `done` are 0. While idle, `pwr_on` equals `keep_on`.
- R2: A start accepted with `keep_on`=0 begins with a power-up phase lasting `pwrup_len`+1 SAR ticks. During this phase `pwrup_ph` and `track` are both 1.
- R3: A start accepted with `keep_on`=1 skips power-up and begins with a tracking slot (`track`=1, `pwrup_ph`=0).
- R4: One start produces `burst_len` conversions, with a value of 0 treated as 1. A burst of 4 is supported.
- R5: With `fixed_trk`=0, a tracking slot of `track_len`+1 ticks precedes every conversion except the first one after power-up.
- R6: With `fixed_trk`=1, a tracking slot of exactly 4 ticks precedes every conversion, including the first, whatever `pwrup_len` and `track_len` hold.
- R7: Each conversion holds `convert`=1 for RES_W+1 SAR ticks (11 at the default).
- R8: A `conv_start` pulse that arrives while `busy`=1 is ignored: the burst continues unchanged and no new burst follows.
- R9: `busy` is 1 from the cycle after the accepted start through the last conversion. `done` is 1 for exactly one cycle, which is the first cycle in which `busy` is back at 0.
- R10: After a burst with `keep_on`=0, `pwr_on` returns to 0.
- R11: `burst_len`, `pwrup_len`, `track_len` and `fixed_trk` are sampled when a start is accepted. Changes made during a burst do not affect it.
- R12: A phase advances only on cycles where `sar_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sar_tick | input | 1 | One-cycle SAR clock enable |
| keep_on | input | 1 | 1 keeps the converter biased while idle |
| burst_len | input | CNT_W | Conversions per burst (0 means 1) |
| pwrup_len | input | PU_W | Power-up phase length minus one, in ticks |
| track_len | input | TK_W | Tracking slot length minus one, in ticks |
| fixed_trk | input | 1 | 1 forces a 4-tick tracking slot before every conversion |
| conv_start | input | 1 | Convert-start pulse |
| pwr_on | output | 1 | Analog core bias enable |
| pwrup_ph | output | 1 | High during the power-up phase |
| track | output | 1 | Track strobe |
| convert | output | 1 | Convert strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
A wrong state shows up as a strobe pattern that is out of place in the phase sequence. Because every phase is observed by its length in SAR ticks, a state register or timer that is off by one shows up as a wrong tick count as soon as the affected phase ends, which is at most one conversion later. A wrong repeat counter shows up only at the end of the burst, either as an extra conversion or as `done` arriving early. A restart caused by an ignored start corrupts the phase sequence from the next phase onward.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_TRACK,
        ST_CONV
    } bseq_state_e;

    localparam int unsigned XTRK_TICKS = 4;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bseq_phase_timer.sv
module bseq_phase_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);

    logic [W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (tick && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign expire = tick && (rem_q == '0);

    // R12: without a tick and without a reload the remaining count holds
    p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(rem_q))
        else $error("phase timer moved without a tick");

endmodule

// File: rtl/bseq_rep_counter.sv
module bseq_rep_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);

    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q == '0);

    // R4: the sequencer never asks for another conversion when none remain
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (left_q != '0))
        else $error("repeat counter underflow");

endmodule

// File: rtl/bseq_burst_ctrl.sv
module bseq_burst_ctrl
    import bseq_pkg::*;
#(
    parameter int unsigned RES_W = 10,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned PU_W  = 5,
    parameter int unsigned TK_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sar_tick,
    input  logic             keep_on,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [PU_W-1:0]  pwrup_len,
    input  logic [TK_W-1:0]  track_len,
    input  logic             fixed_trk,
    input  logic             conv_start,
    output logic             pwr_on,
    output logic             pwrup_ph,
    output logic             track,
    output logic             convert,
    output logic             busy,
    output logic             done
);

    localparam int unsigned CONV_TICKS = RES_W + 1;
    localparam int unsigned TMR_W = max2(max2(PU_W, TK_W), max2($clog2(CONV_TICKS + 1), 2));
    localparam logic [TMR_W-1:0] XT_VAL = TMR_W'(XTRK_TICKS - 1);
    localparam logic [TMR_W-1:0] CV_VAL = TMR_W'(CONV_TICKS - 1);

    bseq_state_e      state_q, state_d;
    logic             fixed_q;
    logic [TK_W-1:0]  trk_q;
    logic             done_q;

    logic             tmr_load, tmr_expire;
    logic [TMR_W-1:0] tmr_val;
    logic             rep_load, rep_dec, rep_last;
    logic [CNT_W-1:0] rep_init;
    logic             done_set;

    assign rep_init = (burst_len == '0) ? '0 : burst_len - 1'b1;

    bseq_phase_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (sar_tick),
        .expire   (tmr_expire)
    );

    bseq_rep_counter #(.W(CNT_W)) u_reps (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rep_load),
        .load_val (rep_init),
        .dec      (rep_dec),
        .last     (rep_last)
    );

    // next state and phase loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rep_load = 1'b0;
        rep_dec  = 1'b0;
        done_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_start) begin
                    rep_load = 1'b1;
                    tmr_load = 1'b1;
                    if (!keep_on) begin
                        state_d = ST_PWRUP;
                        tmr_val = TMR_W'(pwrup_len);
                    end else begin
                        state_d = ST_TRACK;
                        tmr_val = fixed_trk ? XT_VAL : TMR_W'(track_len);
                    end
                end
            end
            ST_PWRUP: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    if (fixed_q) begin
                        state_d = ST_TRACK;
                        tmr_val = XT_VAL;
                    end else begin
                        state_d = ST_CONV;
                        tmr_val = CV_VAL;
                    end
                end
            end
            ST_TRACK: begin
                if (tmr_expire) begin
                    state_d  = ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = CV_VAL;
                end
            end
            ST_CONV: begin
                if (tmr_expire) begin
                    if (rep_last) begin
                        state_d  = ST_IDLE;
                        done_set = 1'b1;
                    end else begin
                        state_d  = ST_TRACK;
                        rep_dec  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = fixed_q ? XT_VAL : TMR_W'(trk_q);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // burst settings captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fixed_q <= 1'b0;
            trk_q   <= '0;
        end else if ((state_q == ST_IDLE) && conv_start) begin
            fixed_q <= fixed_trk;
            trk_q   <= track_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_set;
        end
    end

    // outputs
    always_comb begin
        pwrup_ph = (state_q == ST_PWRUP);
        track    = (state_q == ST_PWRUP) || (state_q == ST_TRACK);
        convert  = (state_q == ST_CONV);
        busy     = (state_q != ST_IDLE);
        pwr_on   = busy || keep_on;
        done     = done_q;
    end

    // R12: a running phase never changes state on a cycle without a tick
    p_stall_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sar_tick && (state_q != ST_IDLE)) |=> $stable(state_q))
        else $error("state moved without a SAR tick");

    // R8: a start pulse during a burst does not end it
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_start && !(convert && tmr_expire)) |=> busy)
        else $error("start during burst disturbed it");

    // R9: done lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    // R9: busy falling is accompanied by done
    p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done)
        else $error("busy fell without done");

    // R10: an unbiased converter is off when the burst completes
    p_dark_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !keep_on) |-> !pwr_on)
        else $error("converter left powered");

endmodule

// File: tb/bseq_burst_ctrl_tb_top.sv
module bseq_burst_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CONV_T     = 11;

    localparam logic [2:0] C_PU   = 3'b110;
    localparam logic [2:0] C_TRK  = 3'b010;
    localparam logic [2:0] C_CNV  = 3'b001;
    localparam logic [2:0] C_DONE = 3'b111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       keep_on = 1'b0;
    logic [3:0] burst_len = 4'd1;
    logic [4:0] pwrup_len = 5'd0;
    logic [3:0] track_len = 4'd0;
    logic       fixed_trk = 1'b0;
    logic       conv_start = 1'b0;
    logic       sar_tick;
    logic       pwr_on, pwrup_ph, track, convert, busy, done;

    int tick_div = 1;
    int tick_ctr = 0;
    int checks = 0;
    int errors = 0;
    int bursts_seen = 0;
    bit finished = 0;

    logic [2:0] q_code[$];
    int         q_ticks[$];
    string      q_tag[$];

    logic [2:0] prev_code = 3'b000;
    int         run_ticks = 0;
    logic       prev_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) tick_ctr <= (tick_ctr + 1 >= tick_div) ? 0 : tick_ctr + 1;
    assign sar_tick = (tick_ctr == 0);

    bseq_burst_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sar_tick(sar_tick), .keep_on(keep_on),
        .burst_len(burst_len), .pwrup_len(pwrup_len), .track_len(track_len),
        .fixed_trk(fixed_trk), .conv_start(conv_start), .pwr_on(pwr_on),
        .pwrup_ph(pwrup_ph), .track(track), .convert(convert), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] c, input int t, input string tag);
        q_code.push_back(c);
        q_ticks.push_back(t);
        q_tag.push_back(tag);
    endtask

    task automatic observe(input logic [2:0] c, input int t);
        checks++;
        if (q_code.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected phase actual=%0d/%0d expected=none", c, t);
        end else begin
            logic [2:0] ec;
            int et;
            string tg;
            ec = q_code.pop_front();
            et = q_ticks.pop_front();
            tg = q_tag.pop_front();
            if (ec != c || et != t) begin
                errors++;
                $display("FAIL %s phase actual=%0d/%0d expected=%0d/%0d", tg, c, t, ec, et);
            end
        end
    endtask

    // monitor: phase runs measured in SAR ticks
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [2:0] code;
            code = {pwrup_ph, track, convert};
            if (code != prev_code) begin
                if (prev_code != 3'b000) observe(prev_code, run_ticks);
                run_ticks = 0;
                prev_code = code;
            end
            if (code != 3'b000 && sar_tick) run_ticks++;
            if (done) begin
                observe(C_DONE, 0);
                check(!busy, "R9 busy low with done", busy, 0);
                check(!prev_done, "R9 done single cycle", prev_done, 0);
                bursts_seen++;
            end
            prev_done = done;
        end
    end

    task automatic plan_burst(input bit keep, input bit fixed, input int n, input int pu, input int trk);
        int nn;
        nn = (n == 0) ? 1 : n;
        if (!keep) push(C_PU, pu + 1, "R2");
        for (int i = 0; i < nn; i++) begin
            if (keep || fixed || i > 0)
                push(C_TRK, fixed ? 4 : trk + 1, fixed ? "R6" : ((keep && i == 0) ? "R3" : "R5"));
            push(C_CNV, CONV_T, "R4 R7");
        end
        push(C_DONE, 0, "R9");
    endtask

    task automatic wait_burst(input int b0);
        while (bursts_seen == b0) @(negedge clk);
    endtask

    task automatic run_burst(input bit keep, input bit fixed, input int n, input int pu,
                             input int trk, input int div);
        int b0;
        @(negedge clk);
        keep_on = keep; fixed_trk = fixed; burst_len = 4'(n);
        pwrup_len = 5'(pu); track_len = 4'(trk); tick_div = div;
        plan_burst(keep, fixed, n, pu, trk);
        b0 = bursts_seen;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        wait_burst(b0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9 idle after burst", busy, 0);
        if (!keep) check(pwr_on == 1'b0, "R10 powered down", pwr_on, 0);
        else       check(pwr_on == 1'b1, "R1 stays biased", pwr_on, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!pwrup_ph && !track && !convert, "R1 strobes in reset", {pwrup_ph, track, convert}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle flags", {busy, done}, 0);
        check(pwr_on == 1'b0, "R1 off while idle", pwr_on, 0);
        keep_on = 1'b1;
        @(negedge clk);
        check(pwr_on == 1'b1, "R1 follows keep_on", pwr_on, 1);
        keep_on = 1'b0;
        @(negedge clk);

        run_burst(0, 0, 4, 5, 2, 1);   // R2 R4 R5 R7
        run_burst(0, 1, 4, 3, 9, 1);   // R6
        run_burst(1, 0, 2, 0, 6, 3);   // R3 R12
        run_burst(1, 1, 3, 7, 11, 2);  // R6 R12
        run_burst(0, 0, 0, 1, 0, 1);   // R4 zero means one

        // R8 R11: second start and field changes during a burst
        begin
            int b0;
            @(negedge clk);
            keep_on = 0; fixed_trk = 0; burst_len = 4'd3; pwrup_len = 5'd2;
            track_len = 4'd1; tick_div = 1;
            plan_burst(0, 0, 3, 2, 1);
            b0 = bursts_seen;
            conv_start = 1'b1;
            @(negedge clk);
            conv_start = 1'b0;
            repeat (6) @(negedge clk);
            burst_len = 4'd7; pwrup_len = 5'd20; track_len = 4'd15; fixed_trk = 1'b1;
            conv_start = 1'b1;
            @(negedge clk);
            conv_start = 1'b0;
            @(negedge clk);
            check(busy == 1'b1, "R8 burst continues", busy, 1);
            wait_burst(b0);
            repeat (20) @(negedge clk);
            check(bursts_seen == b0 + 1, "R8 no extra burst", bursts_seen, b0 + 1);
            check(busy == 1'b0, "R11 idle after sampled burst", busy, 0);
        end

        check(q_code.size() == 0, "R4 all expected phases seen", q_code.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule